// File: doc/BRIEF.md
# Variable-Length Horizontal Slot Sequencer

This block divides each video line into numbered access slots for a display controller that has two horizontal modes. It counts master clocks from the start of the line and reports the current slot index, a one-clock strobe at the start of every slot, and the length of the current slot in master clocks. It also pulses a vertical-interrupt pending signal at a fixed point in the line, and that point depends on the mode.

In the narrow mode every slot is 20 clocks long. In the wide mode slots are 16 clocks long, except for a stretched window of 17 slots that begins at the horizontal-sync position. The slots in that window follow an irregular length pattern and together last 332 clocks. After the window, uniform 16-clock slots resume, with their numbering offset to follow on from the window.

The mode is sampled only when a line begins. Changing the mode request in the middle of a line therefore never alters the current line's slot pattern.

Top module: `hslot_seq`

## Requirements
- R1: In the narrow mode (wide_sel_i sampled as 0), slot_o equals the line clock divided by 20, rounded down, and slot_len_o is 20.
- R2: In the wide mode (wide_sel_i sampled as 1), for line clocks below 336, slot_o equals the line clock divided by 16, rounded down, and slot_len_o is 16.
- R3: In the wide mode, slots 21 to 37 start at line clock 336 and have lengths 19,20,20,20,18,20,20,20,18,20,20,20,18,20,20,20,19, in that order.
- R4: In the wide mode, from line clock 668 onward, slot_o equals (line clock - 668)/16 + 38, and slot_len_o is 16.
- R5: slot_stb_o is 1 for exactly the first master clock of each slot and 0 otherwise. slot_o does not change while slot_stb_o is 0.
- R6: vint_o is 1 for a single clock, when the line clock equals 752 in the wide mode or 1200 in the narrow mode.
- R7: The mode is taken from wide_sel_i only at a line start. A change of wide_sel_i in the middle of a line has no effect on slot_o or slot_len_o for that line.
- R8: Asynchronous reset (rst_ni low) sets the line clock to 0, the slot to 0 and the mode to narrow. A reset therefore starts a narrow line.
- R9: A line start (line_start_i high at a rising edge) restarts the line clock at 0 and slot 0, with the strobe set, even when it arrives in the middle of a slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_start_i | input | 1 | Restarts the line count at the next edge and latches the mode |
| wide_sel_i | input | 1 | Mode request from control registers: 1 selects wide, 0 selects narrow |
| slot_o | output | SLOT_W (8) | Current slot index |
| slot_stb_o | output | 1 | High during the first master clock of each slot |
| slot_len_o | output | LEN_W (5) | Length of the current slot in master clocks |
| vint_o | output | 1 | Vertical-interrupt pending pulse |

## Verification
All four outputs are decoded from registers, so each one reflects a stimulus that was sampled at a rising edge from immediately after that edge. For example, a line start taken at edge k makes slot 0 and the strobe visible in the cycle that follows edge k. The bench applies inputs and compares outputs on falling edges. After each comparison it advances a behavioural line-clock model by one edge, so every expected value belongs to exactly the edge count the design has seen. Slot index, slot length and strobe are recomputed from the model's line clock by division and by a walk through the window lengths, not by copying a counter.

// File: rtl/hslot_pkg.sv
package hslot_pkg;
  typedef enum logic {
    H_NARROW = 1'b0,
    H_WIDE   = 1'b1
  } hmode_e;
endpackage

// File: rtl/hslot_len.sv
module hslot_len
  import hslot_pkg::*;
#(
  parameter int SLOT_W      = 8,
  parameter int LEN_W       = 5,
  parameter int NARROW_LEN  = 20,
  parameter int WIDE_LEN    = 16,
  parameter int WIN_FIRST   = 21,
  parameter int WIN_SLOTS   = 17,
  parameter int EDGE_LEN    = 19,
  parameter int SHORT_LEN   = 18,
  parameter int LONG_LEN    = 20,
  parameter int SHORT_EVERY = 4
) (
  input  hmode_e            mode_i,
  input  logic [SLOT_W-1:0] slot_i,
  output logic [LEN_W-1:0]  len_o
);
  localparam logic [SLOT_W-1:0] FIRST  = SLOT_W'(WIN_FIRST);
  localparam logic [SLOT_W-1:0] LAST_K = SLOT_W'(WIN_SLOTS - 1);
  localparam logic [SLOT_W-1:0] STEP   = SLOT_W'(SHORT_EVERY);

  logic [SLOT_W-1:0] k;
  logic              in_win;

  // window pattern: ends are EDGE_LEN, every STEP-th inner slot is SHORT_LEN
  always_comb begin
    k      = slot_i - FIRST;
    in_win = (slot_i >= FIRST) && (k <= LAST_K);
    if (mode_i == H_NARROW)            len_o = LEN_W'(NARROW_LEN);
    else if (!in_win)                  len_o = LEN_W'(WIDE_LEN);
    else if (k == '0 || k == LAST_K)   len_o = LEN_W'(EDGE_LEN);
    else if ((k % STEP) == '0)         len_o = LEN_W'(SHORT_LEN);
    else                               len_o = LEN_W'(LONG_LEN);
  end
endmodule

// File: rtl/hslot_vint.sv
module hslot_vint
  import hslot_pkg::*;
#(
  parameter int LCLK_W    = 12,
  parameter int WIDE_AT   = 752,
  parameter int NARROW_AT = 1200
) (
  input  hmode_e            mode_i,
  input  logic [LCLK_W-1:0] lclk_i,
  output logic              vint_o
);
  localparam logic [LCLK_W-1:0] W_AT = LCLK_W'(WIDE_AT);
  localparam logic [LCLK_W-1:0] N_AT = LCLK_W'(NARROW_AT);

  always_comb vint_o = (lclk_i == ((mode_i == H_WIDE) ? W_AT : N_AT));
endmodule

// File: rtl/hslot_seq.sv
module hslot_seq
  import hslot_pkg::*;
#(
  parameter int SLOT_W           = 8,
  parameter int LEN_W            = 5,
  parameter int LCLK_W           = 12,
  parameter int NARROW_LEN       = 20,
  parameter int WIDE_LEN         = 16,
  parameter int WIN_FIRST        = 21,
  parameter int WIN_SLOTS        = 17,
  parameter int VINT_SLOT_WIDE   = 47,
  parameter int VINT_SLOT_NARROW = 60
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_start_i,
  input  logic              wide_sel_i,
  output logic [SLOT_W-1:0] slot_o,
  output logic              slot_stb_o,
  output logic [LEN_W-1:0]  slot_len_o,
  output logic              vint_o
);
  localparam int WIDE_AT   = VINT_SLOT_WIDE * WIDE_LEN;
  localparam int NARROW_AT = VINT_SLOT_NARROW * NARROW_LEN;
  localparam logic [SLOT_W-1:0] WIN_LO = SLOT_W'(WIN_FIRST);
  localparam logic [SLOT_W-1:0] WIN_HI = SLOT_W'(WIN_FIRST + WIN_SLOTS);

  hmode_e            mode_q;
  logic [LCLK_W-1:0] lclk_q;
  logic [SLOT_W-1:0] slot_q;
  logic [LEN_W-1:0]  phase_q;
  logic [LEN_W-1:0]  slot_len;
  logic              phase_last;

  hslot_len #(
    .SLOT_W(SLOT_W), .LEN_W(LEN_W), .NARROW_LEN(NARROW_LEN), .WIDE_LEN(WIDE_LEN),
    .WIN_FIRST(WIN_FIRST), .WIN_SLOTS(WIN_SLOTS)
  ) u_len (
    .mode_i(mode_q), .slot_i(slot_q), .len_o(slot_len)
  );

  hslot_vint #(
    .LCLK_W(LCLK_W), .WIDE_AT(WIDE_AT), .NARROW_AT(NARROW_AT)
  ) u_vint (
    .mode_i(mode_q), .lclk_i(lclk_q), .vint_o(vint_o)
  );

  assign phase_last = (phase_q == slot_len - LEN_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= H_NARROW;
      lclk_q  <= '0;
      slot_q  <= '0;
      phase_q <= '0;
    end else if (line_start_i) begin
      mode_q  <= hmode_e'(wide_sel_i);
      lclk_q  <= '0;
      slot_q  <= '0;
      phase_q <= '0;
    end else begin
      if (lclk_q != '1) lclk_q <= lclk_q + LCLK_W'(1);  // saturate on overlong lines
      if (phase_last) begin
        phase_q <= '0;
        slot_q  <= slot_q + SLOT_W'(1);
      end else begin
        phase_q <= phase_q + LEN_W'(1);
      end
    end
  end

  assign slot_o     = slot_q;
  assign slot_len_o = slot_len;
  assign slot_stb_o = (phase_q == '0);

  p_slot_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slot_stb_o |-> $stable(slot_o));

  p_slot_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_stb_o && $past(rst_ni) && !$past(line_start_i))
      |-> slot_o == SLOT_W'($past(slot_o) + SLOT_W'(1)));

  p_len_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_len_o >= LEN_W'(WIDE_LEN) && slot_len_o <= LEN_W'(NARROW_LEN));

  p_win_stretch_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == H_WIDE && slot_o >= WIN_LO && slot_o < WIN_HI)
      |-> slot_len_o != LEN_W'(WIDE_LEN));

  p_vint_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vint_o |=> !vint_o);

  p_mode_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !$past(line_start_i)) |-> $stable(mode_q));
endmodule

// File: tb/tb_hslot_seq.sv
`timescale 1ns/1ps
module tb_hslot_seq;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b1;
  logic       line_start_i = 1'b0;
  logic       wide_sel_i = 1'b0;
  logic [7:0] slot_o;
  logic       slot_stb_o;
  logic [4:0] slot_len_o;
  logic       vint_o;

  hslot_seq dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .line_start_i(line_start_i), .wide_sel_i(wide_sel_i),
    .slot_o(slot_o), .slot_stb_o(slot_stb_o), .slot_len_o(slot_len_o), .vint_o(vint_o)
  );

  always #5 clk_i = ~clk_i;

  int    errors = 0;
  int    checks = 0;
  int    m_lclk = 0;
  bit    m_wide = 1'b0;
  bit    armed  = 1'b0;
  bit    done   = 1'b0;
  string phase_tag = "";

  task automatic chk(input string tag, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d (lclk=%0d wide=%0d)", tag, what, got, exp, m_lclk, m_wide);
    end
  endtask

  function automatic int win_len(input int k);
    if (k == 0 || k == 16) return 19;
    if (k % 4 == 0) return 18;
    return 20;
  endfunction

  task automatic compare_all();
    int    s, ln, c;
    bit    st;
    string tag;
    if (!m_wide) begin
      s = m_lclk / 20; st = (m_lclk % 20 == 0); ln = 20; tag = "R1";
    end else if (m_lclk < 336) begin
      s = m_lclk / 16; st = (m_lclk % 16 == 0); ln = 16; tag = "R2";
    end else if (m_lclk < 668) begin
      c = 336; s = 0; st = 0; ln = 0; tag = "R3";
      for (int k = 0; k < 17; k++) begin
        if (m_lclk < c + win_len(k)) begin
          s = 21 + k; st = (m_lclk == c); ln = win_len(k);
          break;
        end
        c += win_len(k);
      end
    end else begin
      s = (m_lclk - 668) / 16 + 38; st = ((m_lclk - 668) % 16 == 0); ln = 16; tag = "R4";
    end
    if (phase_tag != "") tag = phase_tag;
    chk(tag, "slot", int'(slot_o), s & 255);
    chk(tag, "len", int'(slot_len_o), ln);
    chk("R5", "strobe", int'(slot_stb_o), int'(st));
    chk("R6", "vint", int'(vint_o), int'(m_wide ? (m_lclk == 752) : (m_lclk == 1200)));
  endtask

  task automatic step(input bit ls, input bit ws, input bit rs);
    @(negedge clk_i);
    if (armed) compare_all();
    line_start_i = ls;
    wide_sel_i   = ws;
    rst_ni       = rs;
    if (!rs) begin
      m_lclk = 0; m_wide = 1'b0; armed = 1'b1;
    end else if (ls) begin
      m_lclk = 0; m_wide = ws;
    end else if (m_lclk < 4095) begin
      m_lclk++;
    end
  endtask

  task automatic run(input int n, input bit ws);
    for (int i = 0; i < n; i++) step(1'b0, ws, 1'b1);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #1 rst_ni = 1'b0;
    phase_tag = "R8";
    step(1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b1, 1'b1);           // wide request without line start: ignored
    step(1'b0, 1'b1, 1'b1);
    phase_tag = "";
    run(1300, 1'b0);                  // R1 narrow line incl. vint at 1200
    phase_tag = "R9";
    step(1'b1, 1'b1, 1'b1);           // line start to wide
    run(3, 1'b1);
    phase_tag = "";
    run(1000, 1'b1);                  // R2 R3 R4, vint at 752
    step(1'b1, 1'b0, 1'b1);           // narrow line
    run(100, 1'b0);
    phase_tag = "R7";
    run(400, 1'b1);                   // mid-line wide request ignored
    phase_tag = "";
    step(1'b1, 1'b1, 1'b1);           // wide line
    run(350, 1'b1);
    phase_tag = "R7";
    run(500, 1'b0);                   // mid-line narrow request ignored
    phase_tag = "";
    run(7, 1'b1);
    phase_tag = "R9";
    step(1'b1, 1'b1, 1'b1);           // restart in mid slot
    run(2, 1'b1);
    phase_tag = "";
    run(3400, 1'b1);                  // long wide line
    phase_tag = "R8";
    step(1'b0, 1'b1, 1'b0);           // asynchronous reset mid-line
    step(1'b0, 1'b1, 1'b1);
    run(3, 1'b1);
    phase_tag = "";
    run(40, 1'b1);
    @(negedge clk_i);
    compare_all();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule